// File: doc/BRIEF.md
# Task Dispatcher with Operand Pull and Suspend Substitution

This block sits between the producers of task activations and the instruction decoder of a multithreaded I/O processor. Every activation is an entry of a 5-bit process number and one data byte, kept in a first-in first-out queue. When no process is running, the entry at the head of the queue is taken and its process is made the active thread.

While a thread runs, its operand-pull instruction is answered here. The first pull of an invocation receives the byte of the entry that launched the thread. A later pull receives the next queued byte only when that entry names the same process. Otherwise the block tells the decoder to execute a suspend in place of the pull, and on the same clock edge it launches the process named by the head entry, if the queue holds one.

The pulled byte goes to one of two destination registers, A or B, chosen by the instruction. The block drives a separate write strobe for each.

Top module: `task_dispatch`

## Requirements
- R1: After synchronous reset, `run_valid`, `pull_ack`, `wr_a`, `wr_b`, `pull_suspend` and `push_overflow` are all low.
- R2: At the first rising edge on which no process is active and the queue holds an entry, the process named by the head entry becomes active (`run_valid` high, `run_pid` equal to its number), and that entry is removed from the queue.
- R3: The first pull of an invocation is acknowledged combinationally in the same cycle, and `pull_data` carries the byte of the entry that launched the invocation.
- R4: A later pull, when the head entry names the active process, is acknowledged in the same cycle with that entry's byte, and the entry is removed at the next edge.
- R5: A later pull, when the head entry names a different process, raises `pull_suspend` with no acknowledge. At the next edge that entry's process becomes active, and its first pull returns that entry's byte.
- R6: A later pull with an empty queue raises `pull_suspend` with no acknowledge, and after the next edge no process is active.
- R7: On an acknowledge, `pull_dst` = 0 raises `wr_a` only and `pull_dst` = 1 raises `wr_b` only. Without an acknowledge, neither strobe is raised.
- R8: Entries are delivered in the order in which they were pushed.
- R9: A push at an edge where the queue already holds DEPTH entries is discarded, and `push_overflow` is high for the one cycle after that edge.
- R10: A pull while no process is active has no effect: it raises no acknowledge, no strobe and no suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Offer an activation entry this cycle |
| push_pid | input | 5 | Target process number of the offered entry |
| push_data | input | 8 | Data byte of the offered entry |
| push_overflow | output | 1 | One-cycle pulse: the previous push was discarded |
| pull_req | input | 1 | Decoder issues an operand pull this cycle |
| pull_dst | input | 1 | Destination register of the pull: 0 = A, 1 = B |
| pull_ack | output | 1 | Pull is answered with `pull_data` |
| pull_data | output | 8 | Byte returned to the pull |
| wr_a | output | 1 | Write strobe for register A |
| wr_b | output | 1 | Write strobe for register B |
| pull_suspend | output | 1 | Decoder must substitute suspend for the pull |
| run_valid | output | 1 | A process is active |
| run_pid | output | 5 | Number of the active process |

## Verification
The assertions take for granted that `pull_req` is a single-cycle request and that the decoder honours `pull_suspend` by issuing no further pull for the suspended thread. The assertions do not assume that pushes are rate-limited: overflow is treated as legal input, and the assertions check that a full queue holds its occupancy. The stimulus drives every input half a cycle before the edge and never repeats a pull after a suspend in the same cycle. It fills the queue while the active thread stays silent, so that the only pushes that overflow are the ones it intends.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;

    localparam int PID_W  = 5;
    localparam int DATA_W = 8;

    typedef logic [PID_W-1:0]  pid_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        pid_t  pid;
        byte_t data;
    } task_entry_t;

    typedef enum logic {
        DST_A = 1'b0,
        DST_B = 1'b1
    } dst_sel_e;

    function automatic task_entry_t mk_entry(pid_t p, byte_t d);
        task_entry_t e;
        e.pid  = p;
        e.data = d;
        return e;
    endfunction

endpackage

// File: rtl/tdisp_queue.sv
module tdisp_queue
    import tdisp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  task_entry_t wr_entry,
    input  logic        rd_en,
    output task_entry_t head,
    output logic        not_empty,
    output logic        full,
    output logic        overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    task_entry_t   slots [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] count;
    logic          wr_ok, ovf_q;

    generate
        if (POW2) begin : g_wrap_natural
            always_comb begin
                wr_nxt = wr_ptr + AW'(1);
                rd_nxt = rd_ptr + AW'(1);
            end
        end else begin : g_wrap_compare
            always_comb begin
                wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
                rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            end
        end
    endgenerate

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign wr_ok     = wr_en && !full;
    assign head      = slots[rd_ptr];
    assign overflow  = ovf_q;

    always_ff @(posedge clk) begin
        if (wr_ok) slots[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            ovf_q <= wr_en && full;
            if (wr_ok) wr_ptr <= wr_nxt;
            if (rd_en) rd_ptr <= rd_nxt;
            case ({wr_ok, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> not_empty);

endmodule

// File: rtl/tdisp_ctrl.sv
module tdisp_ctrl
    import tdisp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  task_entry_t head,
    input  logic        head_valid,
    output logic        pop,
    input  logic        pull_req,
    input  logic        pull_dst,
    output logic        pull_ack,
    output byte_t       pull_data,
    output logic        wr_a,
    output logic        wr_b,
    output logic        pull_suspend,
    output logic        run_valid,
    output pid_t        run_pid
);
    logic  act_q, first_q;
    pid_t  pid_q;
    byte_t start_q;
    logic  hit, start_new, take_next;

    assign hit          = head_valid && (head.pid == pid_q);
    assign pull_ack     = pull_req && act_q && (first_q || hit);
    assign pull_suspend = pull_req && act_q && !first_q && !hit;
    assign take_next    = pull_ack && !first_q;
    assign start_new    = (!act_q || pull_suspend) && head_valid;
    assign pop          = take_next || start_new;
    assign pull_data    = first_q ? start_q : head.data;
    assign wr_a         = pull_ack && (dst_sel_e'(pull_dst) == DST_A);
    assign wr_b         = pull_ack && (dst_sel_e'(pull_dst) == DST_B);
    assign run_valid    = act_q;
    assign run_pid      = pid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            first_q <= 1'b0;
            pid_q   <= '0;
            start_q <= '0;
        end else if (start_new) begin
            act_q   <= 1'b1;
            first_q <= 1'b1;
            pid_q   <= head.pid;
            start_q <= head.data;
        end else if (pull_suspend) begin
            act_q   <= 1'b0;
            first_q <= 1'b0;
        end else if (pull_ack && first_q) begin
            first_q <= 1'b0;
        end
    end

    // R7
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        pull_ack |-> $countones({wr_a, wr_b}) == 1);

    // R5
    ack_suspend_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pull_ack && pull_suspend));

    // R6
    empty_suspend_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pull_suspend && !head_valid) |=> !run_valid);

    // R2
    idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_valid && head_valid) |=> (run_valid && run_pid == $past(head.pid)));

    // R10
    idle_pull_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run_valid |-> !(pull_ack || pull_suspend || wr_a || wr_b));

endmodule

// File: rtl/task_dispatch.sv
module task_dispatch
    import tdisp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [PID_W-1:0]  push_pid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_overflow,
    input  logic              pull_req,
    input  logic              pull_dst,
    output logic              pull_ack,
    output logic [DATA_W-1:0] pull_data,
    output logic              wr_a,
    output logic              wr_b,
    output logic              pull_suspend,
    output logic              run_valid,
    output logic [PID_W-1:0]  run_pid
);
    task_entry_t head;
    logic        head_valid, q_full, pop;

    tdisp_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (push_valid),
        .wr_entry  (mk_entry(push_pid, push_data)),
        .rd_en     (pop),
        .head      (head),
        .not_empty (head_valid),
        .full      (q_full),
        .overflow  (push_overflow)
    );

    tdisp_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .head         (head),
        .head_valid   (head_valid),
        .pop          (pop),
        .pull_req     (pull_req),
        .pull_dst     (pull_dst),
        .pull_ack     (pull_ack),
        .pull_data    (pull_data),
        .wr_a         (wr_a),
        .wr_b         (wr_b),
        .pull_suspend (pull_suspend),
        .run_valid    (run_valid),
        .run_pid      (run_pid)
    );

    // R9
    overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
        push_overflow |-> $past(push_valid));

endmodule

// File: tb/sim_task_dispatch.sv
`timescale 1ns/1ps
module sim_task_dispatch;

    localparam int DEPTH = 8;
    localparam int NV    = 9;

    // {push_v, pid[5], data[8], pull, dst, e_ack, e_data[8], e_susp, e_act, e_pid[5]}
    localparam logic [31:0] VEC [NV] = '{
        {1'b1, 5'd3, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'd0},
        {1'b1, 5'd3, 8'h22, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'd0},
        {1'b1, 5'd7, 8'h33, 1'b1, 1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 5'd3},
        {1'b0, 5'd0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h22, 1'b0, 1'b1, 5'd3},
        {1'b0, 5'd0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 5'd3},
        {1'b0, 5'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 5'd7},
        {1'b0, 5'd0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h33, 1'b0, 1'b1, 5'd7},
        {1'b0, 5'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 5'd7},
        {1'b0, 5'd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 5'd0}
    };
    localparam string VREQ [NV] = '{"R10", "R2", "R3", "R4", "R5", "R5", "R3", "R6", "R6"};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_valid = 1'b0;
    logic [4:0] push_pid = '0;
    logic [7:0] push_data = '0;
    logic       pull_req = 1'b0;
    logic       pull_dst = 1'b0;
    logic       push_overflow, pull_ack, wr_a, wr_b, pull_suspend, run_valid;
    logic [7:0] pull_data;
    logic [4:0] run_pid;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    task_dispatch #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_pid(push_pid), .push_data(push_data),
        .push_overflow(push_overflow),
        .pull_req(pull_req), .pull_dst(pull_dst),
        .pull_ack(pull_ack), .pull_data(pull_data),
        .wr_a(wr_a), .wr_b(wr_b), .pull_suspend(pull_suspend),
        .run_valid(run_valid), .run_pid(run_pid)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic pv, logic [4:0] p, logic [7:0] d, logic pr, logic ds);
        @(negedge clk);
        push_valid = pv; push_pid = p; push_data = d;
        pull_req = pr; pull_dst = ds;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        push_valid = 1'b0; pull_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        #1;
        // R1 reset state
        chk("R1", "run_valid", int'(run_valid), 0);
        chk("R1", "pull_ack", int'(pull_ack), 0);
        chk("R1", "wr_a|wr_b", int'(wr_a | wr_b), 0);
        chk("R1", "pull_suspend", int'(pull_suspend), 0);
        chk("R1", "push_overflow", int'(push_overflow), 0);

        // vector table: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            drive(v[31], v[30:26], v[25:18], v[17], v[16]);
            chk(VREQ[i], $sformatf("v%0d ack", i), int'(pull_ack), int'(v[15]));
            if (v[15]) chk(VREQ[i], $sformatf("v%0d data", i), int'(pull_data), int'(v[14:7]));
            chk("R7", $sformatf("v%0d wr_a", i), int'(wr_a), int'(v[15] && !v[16]));
            chk("R7", $sformatf("v%0d wr_b", i), int'(wr_b), int'(v[15] && v[16]));
            chk(VREQ[i], $sformatf("v%0d suspend", i), int'(pull_suspend), int'(v[6]));
            chk(VREQ[i], $sformatf("v%0d run_valid", i), int'(run_valid), int'(v[5]));
            if (v[5]) chk(VREQ[i], $sformatf("v%0d run_pid", i), int'(run_pid), int'(v[4:0]));
        end

        // R9 overflow and R8 ordering: silent thread, queue filled past DEPTH
        do_reset();
        for (int i = 0; i < DEPTH + 2; i++) begin
            drive(1'b1, 5'd1, 8'h40 + 8'(i), 1'b0, 1'b0);
            if (i > 0 && i <= DEPTH)
                chk("R9", $sformatf("no overflow at push %0d", i), int'(push_overflow), 0);
        end
        drive(1'b0, 5'd0, 8'h00, 1'b0, 1'b0);
        chk("R9", "overflow pulse", int'(push_overflow), 1);
        chk("R2", "run_pid after fill", int'(run_pid), 1);
        drive(1'b0, 5'd0, 8'h00, 1'b0, 1'b0);
        chk("R9", "overflow one cycle", int'(push_overflow), 0);
        for (int i = 0; i <= DEPTH; i++) begin
            drive(1'b0, 5'd0, 8'h00, 1'b1, 1'(i % 2));
            chk("R8", $sformatf("drain ack %0d", i), int'(pull_ack), 1);
            chk("R8", $sformatf("drain order %0d", i), int'(pull_data), 8'h40 + i);
        end
        drive(1'b0, 5'd0, 8'h00, 1'b1, 1'b0);
        chk("R9", "dropped entry absent", int'(pull_suspend), 1);
        chk("R9", "dropped entry no ack", int'(pull_ack), 0);
        drive(1'b0, 5'd0, 8'h00, 1'b0, 1'b0);
        chk("R6", "idle after empty suspend", int'(run_valid), 0);

        // R5 suspend hands over directly to the waiting process
        drive(1'b1, 5'd9, 8'hA5, 1'b0, 1'b0);
        drive(1'b1, 5'd12, 8'h5A, 1'b0, 1'b0);
        drive(1'b0, 5'd0, 8'h00, 1'b1, 1'b0);
        chk("R3", "first pull pid9", int'(pull_data), 8'hA5);
        drive(1'b0, 5'd0, 8'h00, 1'b1, 1'b0);
        chk("R5", "suspend on foreign head", int'(pull_suspend), 1);
        drive(1'b0, 5'd0, 8'h00, 1'b1, 1'b1);
        chk("R5", "handover pid", int'(run_pid), 12);
        chk("R5", "handover first byte", int'(pull_data), 8'h5A);
        chk("R7", "handover wr_b", int'(wr_b), 1);
        drive(1'b0, 5'd0, 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule